// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked system read and write an external asynchronous static RAM of 4096 words by 4 bits. The RAM has an active-low chip enable, an active-low write enable and one bidirectional 4-bit data bus. Here that bus is split into an output, an output enable and an input, and the pad ring joins them. On the host side a request carries a 12-bit address, a read/write flag and write data. The block answers with a one-cycle done pulse and, for reads, the captured data.

All of the RAM's timing limits are parameters given in nanoseconds, along with the clock period. Each limit becomes a phase length in cycles: the ceiling of the time divided by the period, and never less than one cycle.

A write is controlled by chip enable. First, write enable goes low while chip enable is still high, and the address and data are driven. Then chip enable is held low for the pulse length. Finally both strobes rise together while the data is still driven for one more cycle. Because of this ordering, the RAM never drives the bus during a write, so the controller's output enable cannot collide with the RAM's drivers. A read holds chip enable low and write enable high for the access length, then registers the bus. After that comes a recovery phase, which covers the time the RAM may keep driving after it is deselected.

Top module: `sram_ctrl`

## Requirements
- R1: While rst_ni is low and right after it: sram_ce_n_o=1, sram_we_n_o=1, sram_dq_oe_o=0, done_o=0, ready_o=1.
- R2: A request is taken only on a clock edge with req_i=1 and ready_o=1. ready_o is 0 from the cycle after acceptance until the operation and its recovery have finished. A request raised while ready_o=0 and dropped before ready_o returns has no effect.
- R3: A write runs through three phases. Setup lasts one cycle: chip enable high, write enable low, address and data driven. Pulse lasts PWE_CYC cycles: chip enable low, write enable low. End lasts one cycle: both strobes high, data still driven. done_o is 1 in the cycle after end, which is PWE_CYC+3 cycles after the accepting edge.
- R4: Address and data stay stable for as long as the strobes overlap. Data is driven for at least ceil(T_SD_NS/T_CLK_NS) cycles of the overlap before the write ends.
- R5: sram_dq_oe_o is never 1 while chip enable is low and write enable is high. It is also never 1 within ceil(T_HZCE_NS/T_CLK_NS) cycles after a read deselects the RAM.
- R6: A read holds chip enable low, write enable high, output enable low and the address stable for ACC_CYC cycles. It then registers sram_dq_i into rdata_o, and done_o is 1 ACC_CYC+1 cycles after the accepting edge.
- R7: done_o is a single-cycle pulse, and there is exactly one pulse for each accepted request.
- R8: PWE_CYC = max of ceil(T_PWE_NS/T), ceil(T_SD_NS/T), ceil(T_AW_NS/T) and ceil(T_WC_NS/T)-2. ACC_CYC = ceil(T_AA_NS/T). Each value is at least 1. With the defaults (T=5, 12, 10, 12, 15, 15 ns) this gives PWE_CYC=3 and ACC_CYC=3.
- R9: rdata_o keeps its value until the next read completes. Writes do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Host address |
| wdata_i | input | DATA_W | Host write data |
| ready_o | output | 1 | Controller idle, request may be taken |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DATA_W | Last captured read data |
| sram_addr_o | output | ADDR_W | RAM address lines |
| sram_ce_n_o | output | 1 | RAM chip enable, active low |
| sram_we_n_o | output | 1 | RAM write enable, active low |
| sram_dq_o | output | DATA_W | Data driven toward the RAM |
| sram_dq_oe_o | output | 1 | Drive enable for sram_dq_o |
| sram_dq_i | input | DATA_W | Data returned from the RAM bus |

## Verification
The assertions assume that reset is held for a few cycles before the first request. They also assume that the host's address, data and direction are valid on any edge where a request is taken. No assertion depends on sram_dq_i, because the RAM bus carries meaningful data only at the end of a read. The bench changes host inputs only on falling edges and normally raises a request only when ready_o is seen high. The one exception is a deliberate probe while the controller is busy, which is dropped again before the controller returns to idle. The bench's RAM model drives stale data until the access time has passed, keeps driving for the release time after deselection, and reports contention and any write whose pulse, setup or hold is short.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_W_SETUP,
    ST_W_PULSE,
    ST_W_END,
    ST_R_ACCESS,
    ST_R_RECOVER
  } state_e;

  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe;
  } pin_ctl_t;

  function automatic int unsigned to_cycles(int unsigned t_ns, int unsigned clk_ns);
    int unsigned c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // strobe and drive levels held by each state
  function automatic pin_ctl_t pin_decode(state_e s);
    pin_ctl_t p;
    unique case (s)
      ST_W_SETUP:  p = '{ce_n: 1'b1, we_n: 1'b0, oe: 1'b1};
      ST_W_PULSE:  p = '{ce_n: 1'b0, we_n: 1'b0, oe: 1'b1};
      ST_W_END:    p = '{ce_n: 1'b1, we_n: 1'b1, oe: 1'b1};
      ST_R_ACCESS: p = '{ce_n: 1'b0, we_n: 1'b1, oe: 1'b0};
      default:     p = '{ce_n: 1'b1, we_n: 1'b1, oe: 1'b0};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned PWE_CYC = 3,
  parameter int unsigned ACC_CYC = 3,
  parameter int unsigned RCV_CYC = 2,
  parameter int unsigned CNT_W   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic             expired_i,
  output state_e           state_d_o,
  output logic             ready_o,
  output logic             accept_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             capture_o,
  output logic             finish_o
);

  localparam logic [CNT_W-1:0] PWE_LD = CNT_W'(PWE_CYC - 1);
  localparam logic [CNT_W-1:0] ACC_LD = CNT_W'(ACC_CYC - 1);
  localparam logic [CNT_W-1:0] RCV_LD = CNT_W'(RCV_CYC - 1);

  state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    accept_o   = 1'b0;
    load_o     = 1'b0;
    load_val_o = '0;
    capture_o  = 1'b0;
    finish_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        accept_o = 1'b1;
        load_o   = 1'b1;
        if (we_i) begin
          state_d = ST_W_SETUP;
        end else begin
          state_d    = ST_R_ACCESS;
          load_val_o = ACC_LD;
        end
      end
      ST_W_SETUP: begin
        state_d    = ST_W_PULSE;
        load_o     = 1'b1;
        load_val_o = PWE_LD;
      end
      ST_W_PULSE: if (expired_i) state_d = ST_W_END;
      ST_W_END: begin
        state_d  = ST_IDLE;
        finish_o = 1'b1;
      end
      ST_R_ACCESS: if (expired_i) begin
        state_d    = ST_R_RECOVER;
        capture_o  = 1'b1;
        finish_o   = 1'b1;
        load_o     = 1'b1;
        load_val_o = RCV_LD;
      end
      ST_R_RECOVER: if (expired_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_d_o = state_d;
  assign ready_o   = (state_q == ST_IDLE);

endmodule

// File: rtl/sram_ctrl_pins.sv
module sram_ctrl_pins
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  state_e            state_d_i,
  input  logic              accept_i,
  input  logic              capture_i,
  input  logic              finish_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] sram_dq_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_ce_n_o,
  output logic              sram_we_n_o,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe_o
);

  pin_ctl_t ctl_q;

  // strobes registered from next state: glitch-free, aligned with state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q       <= '{ce_n: 1'b1, we_n: 1'b1, oe: 1'b0};
      done_o      <= 1'b0;
      rdata_o     <= '0;
      sram_addr_o <= '0;
      sram_dq_o   <= '0;
    end else begin
      ctl_q  <= pin_decode(state_d_i);
      done_o <= finish_i;
      if (accept_i) begin
        sram_addr_o <= addr_i;
        sram_dq_o   <= wdata_i;
      end
      if (capture_i) rdata_o <= sram_dq_i;
    end
  end

  assign sram_ce_n_o  = ctl_q.ce_n;
  assign sram_we_n_o  = ctl_q.we_n;
  assign sram_dq_oe_o = ctl_q.oe;

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned DATA_W     = 4,
  parameter int unsigned T_CLK_NS   = 5,
  parameter int unsigned T_AA_NS    = 15,
  parameter int unsigned T_PWE_NS   = 12,
  parameter int unsigned T_SD_NS    = 10,
  parameter int unsigned T_AW_NS    = 12,
  parameter int unsigned T_WC_NS    = 15,
  parameter int unsigned T_HZCE_NS  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_ce_n_o,
  output logic              sram_we_n_o,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe_o,
  input  logic [DATA_W-1:0] sram_dq_i
);

  localparam int unsigned WC_CYC  = to_cycles(T_WC_NS, T_CLK_NS);
  localparam int unsigned WC_PUL  = (WC_CYC > 2) ? WC_CYC - 2 : 1;
  localparam int unsigned PWE_CYC = max2(max2(to_cycles(T_PWE_NS, T_CLK_NS),
                                              to_cycles(T_SD_NS, T_CLK_NS)),
                                         max2(to_cycles(T_AW_NS, T_CLK_NS), WC_PUL));
  localparam int unsigned ACC_CYC = to_cycles(T_AA_NS, T_CLK_NS);
  localparam int unsigned RCV_CYC = to_cycles(T_HZCE_NS, T_CLK_NS);
  localparam int unsigned MAX_CYC = max2(max2(PWE_CYC, ACC_CYC), RCV_CYC);
  localparam int unsigned CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  state_e           state_d;
  logic             accept, load, expired, capture, finish;
  logic [CNT_W-1:0] load_val;

  sram_ctrl_fsm #(
    .PWE_CYC (PWE_CYC),
    .ACC_CYC (ACC_CYC),
    .RCV_CYC (RCV_CYC),
    .CNT_W   (CNT_W)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .expired_i  (expired),
    .state_d_o  (state_d),
    .ready_o    (ready_o),
    .accept_o   (accept),
    .load_o     (load),
    .load_val_o (load_val),
    .capture_o  (capture),
    .finish_o   (finish)
  );

  sram_ctrl_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .expired_o  (expired)
  );

  sram_ctrl_pins #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_pins (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .state_d_i    (state_d),
    .accept_i     (accept),
    .capture_i    (capture),
    .finish_i     (finish),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .sram_dq_i    (sram_dq_i),
    .done_o       (done_o),
    .rdata_o      (rdata_o),
    .sram_addr_o  (sram_addr_o),
    .sram_ce_n_o  (sram_ce_n_o),
    .sram_we_n_o  (sram_we_n_o),
    .sram_dq_o    (sram_dq_o),
    .sram_dq_oe_o (sram_dq_oe_o)
  );

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              ready_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] sram_addr_o,
  input logic              sram_ce_n_o,
  input logic              sram_we_n_o,
  input logic [DATA_W-1:0] sram_dq_o,
  input logic              sram_dq_oe_o
);

  assert_no_contention_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_dq_oe_o |-> !(!sram_ce_n_o && sram_we_n_o));

  assert_read_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sram_ce_n_o) && $past(sram_we_n_o)) |=> !sram_dq_oe_o);

  assert_addr_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_ce_n_o && !$past(sram_ce_n_o)) |-> $stable(sram_addr_o));

  assert_data_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sram_dq_oe_o && $past(sram_dq_oe_o)) |-> $stable(sram_dq_o));

  assert_write_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sram_ce_n_o) && !$past(sram_we_n_o)) |-> sram_dq_oe_o);

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_accept_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o) |=> !ready_o);

endmodule

bind sram_ctrl sram_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .ready_o      (ready_o),
  .done_o       (done_o),
  .sram_addr_o  (sram_addr_o),
  .sram_ce_n_o  (sram_ce_n_o),
  .sram_we_n_o  (sram_we_n_o),
  .sram_dq_o    (sram_dq_o),
  .sram_dq_oe_o (sram_dq_oe_o)
);

// File: tb/sram_ctrl_bench.sv
`timescale 1ns/1ps
module sram_ctrl_bench;

  function automatic int cyc(int t_ns);
    int c;
    c = (t_ns + 4) / 5;
    if (c < 1) c = 1;
    return c;
  endfunction

  localparam int PWE_REQ = cyc(12);
  localparam int SD_REQ  = cyc(10);
  localparam int ACC_REQ = cyc(15);
  localparam int HZ_REQ  = cyc(8);
  localparam int WR_LAT  = 1 + PWE_REQ + 1 + 1;
  localparam int RD_LAT  = ACC_REQ + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [3:0]  wdata = '0;
  logic        ready, done;
  logic [3:0]  rdata;
  logic [11:0] s_addr;
  logic        s_ce_n, s_we_n, s_oe;
  logic [3:0]  s_dq_o, s_dq_i;

  int n_chk = 0, n_fail = 0, n_ops = 0, n_done = 0;

  always #2.5 clk = ~clk;

  sram_ctrl u_sram_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ready_o(ready), .done_o(done), .rdata_o(rdata),
    .sram_addr_o(s_addr), .sram_ce_n_o(s_ce_n), .sram_we_n_o(s_we_n),
    .sram_dq_o(s_dq_o), .sram_dq_oe_o(s_oe), .sram_dq_i(s_dq_i)
  );

  // behavioural RAM model and scoreboard
  logic [3:0] mem [4096];
  logic [3:0] exp_mem [4096];

  function automatic logic [3:0] seed_val(int a);
    return 4'((a ^ (a >> 4) ^ (a >> 8) ^ 5) & 15);
  endfunction

  initial for (int i = 0; i < 4096; i++) begin
    mem[i] = seed_val(i);
    exp_mem[i] = seed_val(i);
  end

  wire rd_pins = !s_ce_n && s_we_n;
  int  rd_cnt = 0, hold_cnt = 0, pulse_cnt = 0, sd_cnt = 0;
  logic rd_prev = 1'b0, wr_prev = 1'b0;
  logic [11:0] raddr_prev = '0, waddr = '0;
  logic [3:0]  dval = '0;

  assign s_dq_i = (rd_pins && rd_cnt >= ACC_REQ) ? mem[s_addr] : ~mem[s_addr];

  task automatic fail_msg(string tag, string what, int act, int exp);
    n_fail++;
    $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
  endtask

  task automatic check_eq(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) fail_msg(tag, what, act, exp);
  endtask

  always @(negedge clk) if (rst_n) begin
    logic wr_now;
    wr_now = !s_ce_n && !s_we_n;
    // R5: controller drive against RAM drive (incl. release window)
    if (s_oe && (rd_pins || hold_cnt > 0)) fail_msg("R5", "bus contention", 1, 0);
    if (rd_pins) hold_cnt = HZ_REQ;
    else if (hold_cnt > 0) hold_cnt--;
    if (rd_pins) rd_cnt = (rd_prev && s_addr == raddr_prev) ? rd_cnt + 1 : 1;
    else rd_cnt = 0;
    rd_prev = rd_pins;
    raddr_prev = s_addr;
    if (wr_now) begin
      if (!wr_prev) begin
        pulse_cnt = 1; sd_cnt = s_oe ? 1 : 0; dval = s_dq_o; waddr = s_addr;
      end else begin
        pulse_cnt++;
        if (s_addr != waddr) fail_msg("R4", "address moved in write", int'(s_addr), int'(waddr));
        if (s_oe && s_dq_o == dval) sd_cnt++;
        else begin sd_cnt = s_oe ? 1 : 0; dval = s_dq_o; end
      end
    end else if (wr_prev) begin
      check_eq("R3", "write pulse cycles ok", int'(pulse_cnt >= PWE_REQ), 1);
      check_eq("R4", "data setup cycles ok", int'(sd_cnt >= SD_REQ), 1);
      check_eq("R3", "data hold at write end", int'(s_oe && s_dq_o == dval), 1);
      mem[waddr] = dval;
    end
    wr_prev = wr_now;
    if (done) n_done++;
  end

  task automatic host_op(input bit wr, input logic [11:0] a, input logic [3:0] d,
                         output logic [3:0] rd, output int lat);
    while (!ready) @(negedge clk);
    req = 1'b1; we = wr; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; lat = 1;
    while (!done) begin @(negedge clk); lat++; end
    rd = rdata;
    n_ops++;
    @(negedge clk);
    check_eq("R7", "done width", int'(done), 0);
  endtask

  task automatic do_write(input logic [11:0] a, input logic [3:0] d);
    logic [3:0] rd; int lat;
    host_op(1'b1, a, d, rd, lat);
    check_eq("R3", "write latency (R8 count)", lat, WR_LAT);
    exp_mem[a] = d;
  endtask

  task automatic do_read(input logic [11:0] a, output logic [3:0] rd);
    int lat;
    host_op(1'b0, a, 4'h0, rd, lat);
    check_eq("R6", "read data", int'(rd), int'(exp_mem[a]));
    check_eq("R8", "read latency", lat, RD_LAT);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fail_msg("R7", "watchdog expired", 1, 0);
    report();
    $finish;
  end

  initial begin
    logic [3:0] rd, keep;
    void'($urandom(32'h0051AB7E));
    repeat (3) @(negedge clk);
    // R1: reset values
    check_eq("R1", "ce_n in reset", int'(s_ce_n), 1);
    check_eq("R1", "we_n in reset", int'(s_we_n), 1);
    check_eq("R1", "oe in reset", int'(s_oe), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1", "done after reset", int'(done), 0);
    check_eq("R1", "ready after reset", int'(ready), 1);

    // address extremes and unwritten location
    do_write(12'h000, 4'hA);
    do_write(12'hFFF, 4'h5);
    do_read(12'h000, rd);
    do_read(12'hFFF, rd);
    do_read(12'h800, rd);
    // every data pattern at one location
    for (int v = 0; v < 16; v++) begin
      do_write(12'h007, 4'(v));
      do_read(12'h007, rd);
    end
    // R9: rdata holds across writes
    do_read(12'h0FF, keep);
    do_write(12'h0FE, ~keep);
    check_eq("R9", "rdata after write", int'(rdata), int'(keep));

    // R2: request while busy is ignored
    while (!ready) @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 12'h123; wdata = 4'h9;
    @(negedge clk);
    req = 1'b0; n_ops++;
    @(negedge clk);
    check_eq("R2", "ready while busy", int'(ready), 0);
    req = 1'b1; we = 1'b1; addr = 12'h456; wdata = ~exp_mem[12'h456];
    @(negedge clk);
    req = 1'b0;
    while (!done) @(negedge clk);
    exp_mem[12'h123] = 4'h9;
    @(negedge clk);
    do_read(12'h456, rd);
    do_read(12'h123, rd);

    // random traffic
    for (int i = 0; i < 400; i++) begin
      logic [11:0] a;
      a = ($urandom_range(0, 3) == 0) ? 12'($urandom) : 12'($urandom_range(0, 15));
      if ($urandom_range(0, 1) == 1) do_write(a, 4'($urandom));
      else do_read(a, rd);
    end

    repeat (4) @(negedge clk);
    check_eq("R7", "done pulses per request", n_done, n_ops);
    report();
    $finish;
  end

endmodule